// File: doc/BRIEF.md
# Reset Source Controller

The block merges four reset causes into one internal reset: the active-low power-on input, an external pin request, a brown-out request and a watchdog timeout strobe. Every request is a synchronous digital signal, except the power-on input, which resets the block asynchronously. After the last request the internal reset stays high for a fixed number of clocks, `DELAY`. A watchdog timeout first turns into a single-clock reset pulse, and the stretch count begins as that pulse ends.

A 4-bit flag register records each cause. It reads back as an 8-bit status byte. Software reads the byte early after start-up and writes zeros to the flags it has handled. Causes that arrive later add to the flags still set, so the next reset can still be traced.

Top module: `reset_source_ctrl`

## Requirements
- R1: While `rst_ni` is low, `sys_rst_o` is 1 and `stat_o` reads 0x01. After `rst_ni` rises, `sys_rst_o` falls exactly `DELAY` rising clock edges later.
- R2: A high `ext_req_i` sets status bit 1 and a high `bor_req_i` sets status bit 2, one edge after the request is sampled. `sys_rst_o` stays high until `DELAY` edges after the last edge at which any request was sampled.
- R3: A rising edge on `wdt_tmo_i` makes `sys_rst_o` high for a one-cycle pulse that starts one edge later. The stretch count starts on the falling edge of that pulse, so `sys_rst_o` falls `DELAY`+1 edges after the strobe was sampled. Status bit 3 is set at the pulse's falling edge.
- R4: Status layout: bit 3 is the watchdog flag, bit 2 brown-out, bit 1 external and bit 0 power-on. Bits 7..4 always read 0, even after a write of ones.
- R5: With `stat_we_i` high, each flag whose `stat_wdata_i` bit is 0 clears at the next edge. Writing 1 leaves a flag unchanged and never sets it.
- R6: Flags from successive resets accumulate until software clears them.
- R7: When a hardware set and a software clear of the same flag occur in one cycle, the flag ends up set.
- R8: A request that arrives while the stretch count is running restarts the count from zero.
- R9: The power-on flag is cleared only by a software write of 0. External, brown-out and watchdog resets leave it as it is. A power-on reset clears the other three flags.
- R10: A watchdog strobe held high for several cycles gives only one reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset request, active low, asynchronous |
| ext_req_i | input | 1 | External pin reset request, synchronous |
| bor_req_i | input | 1 | Brown-out reset request, synchronous |
| wdt_tmo_i | input | 1 | Watchdog timeout strobe, synchronous |
| stat_we_i | input | 1 | Status register write enable |
| stat_wdata_i | input | 8 | Status write data; a 0 in bits 3..0 clears that flag |
| stat_o | output | 8 | Status byte: bits 3..0 are the flags, bits 7..4 are 0 |
| sys_rst_o | output | 1 | Stretched internal reset, active high |

## Verification
Every result is registered, so each effect of a cycle's inputs is due just after the next rising edge. The exception is the watchdog pulse, which takes one further edge before its flag is set. The driver pushes a predicted status byte and reset level for every cycle, each tagged with the cycle it is due in. The monitor compares only at the falling edge of that cycle. The prediction counts down the stretch from the requirement wording, so the release edge for `DELAY` and for `DELAY`+1 is checked to the exact cycle. Power-on cases are checked directly while `rst_ni` is held low.

// File: rtl/rst_ctrl_pkg.sv
package rst_ctrl_pkg;
  localparam int unsigned NFLAGS = 4;
  localparam int unsigned FLAG_POR = 0;
  localparam int unsigned FLAG_EXT = 1;
  localparam int unsigned FLAG_BOR = 2;
  localparam int unsigned FLAG_WDT = 3;
  localparam logic [NFLAGS-1:0] FLAGS_RST = 4'b0001;
  typedef logic [NFLAGS-1:0] flags_t;
endpackage

// File: rtl/rst_wdt_pulse.sv
module rst_wdt_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tmo_i,
  output logic pulse_o
);
  logic prev_q, pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      prev_q  <= tmo_i;
      pulse_q <= tmo_i & ~prev_q;
    end
  end

  assign pulse_o = pulse_q;

  AST_WDT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o); // R3
  AST_WDT_HELD_NO_REPEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_i && prev_q) |=> !pulse_o); // R10
endmodule

// File: rtl/rst_stretch.sv
module rst_stretch #(
  parameter int unsigned DELAY = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic hold_i,
  output logic rst_o
);
  localparam int unsigned CW = (DELAY > 1) ? $clog2(DELAY) : 1;
  localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (restart_i) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        cnt_q  <= '0;
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // pulse cycle itself counts as reset
  assign rst_o = busy_q | hold_i;

  initial begin
    AST_DELAY_NONZERO: assert (DELAY >= 1); // R1
  end

  AST_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (rst_o && cnt_q == '0)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R2
  AST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !restart_i && cnt_q == LAST) |=> !busy_q); // R2
  AST_COUNT_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !restart_i && cnt_q != LAST) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1)); // R2
endmodule

// File: rtl/rst_flag_reg.sv
module rst_flag_reg
  import rst_ctrl_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  flags_t set_i,
  input  logic   we_i,
  input  flags_t wdata_i,
  output flags_t flags_o
);
  flags_t flags_q, clr;

  assign clr = we_i ? ~wdata_i : '0;

  // hardware set overrides software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= FLAGS_RST;
    else         flags_q <= (flags_q & ~clr) | set_i;
  end

  assign flags_o = flags_q;

  AST_NO_SW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flags_q & ~($past(flags_q) | $past(set_i))) == '0)); // R5
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((flags_q & $past(set_i)) == $past(set_i))); // R7
  AST_SW_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && ((~wdata_i & ~set_i) != '0)) |=> ((flags_q & $past(~wdata_i & ~set_i)) == '0)); // R5
  AST_POR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_q[FLAG_POR] && !(we_i && !wdata_i[FLAG_POR])) |=> flags_q[FLAG_POR]); // R9
endmodule

// File: rtl/reset_source_ctrl.sv
module reset_source_ctrl
  import rst_ctrl_pkg::*;
#(
  parameter int unsigned DELAY = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ext_req_i,
  input  logic       bor_req_i,
  input  logic       wdt_tmo_i,
  input  logic       stat_we_i,
  input  logic [7:0] stat_wdata_i,
  output logic [7:0] stat_o,
  output logic       sys_rst_o
);
  logic   wdt_pulse;
  logic   restart;
  flags_t set_vec, flags;
  logic   unused_rsvd;

  assign unused_rsvd = ^stat_wdata_i[7:NFLAGS];

  rst_wdt_pulse i_wdt_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tmo_i  (wdt_tmo_i),
    .pulse_o(wdt_pulse)
  );

  // delay starts when the watchdog pulse falls
  assign restart = ext_req_i | bor_req_i | wdt_pulse;

  rst_stretch #(.DELAY(DELAY)) i_stretch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart),
    .hold_i   (wdt_pulse),
    .rst_o    (sys_rst_o)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[FLAG_EXT] = ext_req_i;
    set_vec[FLAG_BOR] = bor_req_i;
    set_vec[FLAG_WDT] = wdt_pulse;
  end

  rst_flag_reg i_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .we_i   (stat_we_i),
    .wdata_i(stat_wdata_i[NFLAGS-1:0]),
    .flags_o(flags)
  );

  assign stat_o = {{(8-NFLAGS){1'b0}}, flags};

  AST_REQ_HOLDS_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_req_i || bor_req_i) |=> sys_rst_o); // R2
  AST_EXT_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_req_i |=> stat_o[FLAG_EXT]); // R2
  AST_BOR_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bor_req_i |=> stat_o[FLAG_BOR]); // R2
  AST_WDT_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_pulse |=> stat_o[FLAG_WDT]); // R3
  AST_WDT_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdt_tmo_i) |=> sys_rst_o); // R3
endmodule

// File: tb/test_reset_source_ctrl.sv
`timescale 1ns/1ps
module test_reset_source_ctrl;
  localparam int unsigned DLY = 16;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ext_req = 1'b0, bor_req = 1'b0, wdt_tmo = 1'b0, we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] stat;
  logic       sys_rst;

  always #10 clk = ~clk;

  reset_source_ctrl #(.DELAY(DLY)) i_reset_source_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .ext_req_i(ext_req), .bor_req_i(bor_req),
    .wdt_tmo_i(wdt_tmo), .stat_we_i(we), .stat_wdata_i(wdata),
    .stat_o(stat), .sys_rst_o(sys_rst)
  );

  typedef struct {
    int         due;
    logic       rst;
    logic [7:0] st;
    string      tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0, n_chk = 0, n_fail = 0;

  // requirement-level expectation state
  logic [3:0] m_flags = 4'b0001;
  int         m_rem = DLY;
  logic       m_prev = 1'b0, m_pls = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (sys_rst !== e.rst || stat !== e.st) begin
        n_fail++;
        $display("FAIL %s cyc=%0d rst=%0b exp=%0b stat=%h exp=%h",
                 e.tag, cyc, sys_rst, e.rst, stat, e.st);
      end
    end
  end

  // called just after a rising edge; models the coming edge and pushes its result
  task automatic drive(input logic e, input logic b, input logic w,
                       input logic wr, input logic [7:0] wd, input string tag);
    logic [3:0] setv, clrv;
    exp_t it;
    ext_req = e; bor_req = b; wdt_tmo = w; we = wr; wdata = wd;
    setv = {m_pls, b, e, 1'b0};
    clrv = wr ? ~wd[3:0] : 4'b0000;
    m_flags = (m_flags & ~clrv) | setv;
    if (e || b || m_pls) m_rem = DLY;
    else if (m_rem > 0) m_rem--;
    m_pls  = w & ~m_prev;
    m_prev = w;
    it.due = cyc + 1;
    it.rst = (m_rem > 0) || m_pls;
    it.st  = {4'h0, m_flags};
    it.tag = tag;
    q.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 8'h00, tag);
  endtask

  task automatic por(input string tag);
    rst_ni = 1'b0;
    ext_req = 0; bor_req = 0; wdt_tmo = 0; we = 0; wdata = 8'h00;
    m_flags = 4'b0001; m_rem = DLY; m_prev = 0; m_pls = 0;
    q.delete();
    @(negedge clk);
    n_chk++;
    if (stat !== 8'h01 || sys_rst !== 1'b1) begin
      n_fail++;
      $display("FAIL %s during power-on rst=%0b exp=1 stat=%h exp=01", tag, sys_rst, stat);
    end
    repeat (2) @(posedge clk);
    #1 rst_ni = 1'b1;
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog expired cyc=%0d exp=finished", cyc);
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    // R1: power-on state and release after DELAY edges
    @(posedge clk); #1;
    por("R1");
    idle(DLY + 3, "R1");
    // R5: write zero clears power-on flag
    drive(0, 0, 0, 1, 8'h00, "R5");
    // R4 R5: writing ones sets nothing, reserved bits stay zero
    drive(0, 0, 0, 1, 8'hFF, "R4");
    idle(2, "R5");
    // R2: external request, one cycle
    drive(1, 0, 0, 0, 8'h00, "R2");
    idle(DLY + 2, "R2");
    // R2 R6: brown-out held three cycles, flags accumulate
    for (int i = 0; i < 3; i++) drive(0, 1, 0, 0, 8'h00, "R2");
    idle(DLY + 2, "R6");
    // R3 R10: watchdog strobe held three cycles, one pulse
    for (int i = 0; i < 3; i++) drive(0, 0, 1, 0, 8'h00, "R10");
    idle(DLY + 3, "R3");
    // R5: clear only the brown-out flag
    drive(0, 0, 0, 1, 8'hFB, "R5");
    idle(1, "R4");
    // R7: set wins over clear in the same cycle
    drive(1, 0, 0, 1, 8'h00, "R7");
    idle(DLY + 2, "R7");
    // R8: request during delay restarts count
    drive(0, 0, 0, 1, 8'h00, "R8");
    drive(1, 0, 0, 0, 8'h00, "R8");
    idle(8, "R8");
    drive(0, 1, 0, 0, 8'h00, "R8");
    idle(DLY + 2, "R8");
    // R8: watchdog strobe during delay
    drive(1, 0, 0, 0, 8'h00, "R8");
    idle(5, "R8");
    drive(0, 0, 1, 0, 8'h00, "R8");
    idle(DLY + 3, "R8");
    // R9: power-on mid-delay clears others, then others keep the power-on flag
    drive(1, 0, 0, 0, 8'h00, "R9");
    idle(3, "R9");
    por("R9");
    idle(DLY + 2, "R9");
    drive(1, 0, 0, 0, 8'h00, "R9");
    idle(DLY + 1, "R9");
    drive(0, 0, 1, 0, 8'h00, "R9");
    idle(DLY + 3, "R9");
    drive(0, 0, 0, 1, 8'h0E, "R9");
    idle(2, "R9");
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule